// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block is one general-purpose I/O port with a configurable number of pins. It holds a direction register and a data register, and both are reached through a small synchronous read/write bus. When a pin's direction bit is set, the pin drives its latched data bit. When the bit is clear, the pin is an input, and its level is sampled through a synchronizer so that software can read it. The block does not contain the tristate buffers. It exposes a per-pin output enable and a per-pin output value, and external buffers use these.

Two standby conditions are modelled:

- **Hardware standby** clears the port back to its reset configuration.
- **Software standby** freezes the port. Every pin that was an output keeps driving its data bit until standby ends.

A per-pin alternate-function hook lets another on-chip agent, such as a timer, take over a pin. While the hook is active it forces that pin's output enable and supplies the pin's output value.

Top module: `gpio_port_regs`

## Requirements
- R1: Writing the direction register stores the write data, taking effect from the next clock. A stored bit of 1 sets that pin's `pin_oe`, and a stored bit of 0 clears it. Unless overridden, `pin_out` carries the data-register bit.
- R2: A read of the direction address always returns all ones (0xFF for 8 pins), whatever the stored value. The read has no error signalling.
- R3: The direction register decodes at offset 0x8C and the data register at offset 0x8E. A write to one of them leaves the other unchanged.
- R4: After reset both registers are zero, every `pin_oe` is 0, and every `pin_out` is 0.
- R5: While `hw_stby` is high at a clock edge, both registers are cleared to zero. This clear overrides a bus write in the same cycle.
- R6: While `sw_stby` is high and `hw_stby` is low, both registers keep their values and bus writes are ignored. Output pins therefore keep driving their data bits.
- R7: A read of the data address returns the latched data bit for output pins and the synchronized pin level for input pins.
- R8: A change on `pin_in` appears in the data read-back after the second rising clock edge that follows it, and not after the first.
- R9: A write to any address other than 0x8C or 0x8E changes nothing. A read of any such address returns 0x00.
- R10: Where `alt_en` is 1, `pin_oe` is forced to 1 and `pin_out` takes the `alt_val` bit, whatever the direction and data registers hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby; clears the port configuration |
| sw_stby | input | 1 | Software standby; freezes the registers |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the peripheral window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_oe | output | 8 | Per-pin output enable for the tristate buffers |
| pin_out | output | 8 | Per-pin output value |
| alt_en | input | 8 | Per-pin alternate-function takeover |
| alt_val | input | 8 | Output value used where `alt_en` is set |

## Verification
The bench builds the block with its default parameters:

- 8 pins.
- An 8-bit offset.
- Two synchronizer stages.

With these values, the exact offsets 0x8C and 0x8E can be probed, and so can their unmapped neighbours 0x8D and 0x8F. The two-stage setting lets the bench see the input change become visible only after the second edge. A mixed direction pattern puts output and input bits in one data read. Software standby, hardware standby and a write that lands on a hardware-standby cycle are all driven on the same configured port.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned PORT_W = 8;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] dat;
    } port_state_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              wr_dir,
    input  logic              wr_dat,
    input  logic [PORT_W-1:0] wdata,
    output logic [PORT_W-1:0] dir_o,
    output logic [PORT_W-1:0] dat_o
);
    port_state_t st_d;
    port_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (hw_stby) begin
            st_d.dir = '0;
            st_d.dat = '0;
        end else if (!sw_stby) begin
            if (wr_dir) st_d.dir = wdata;
            if (wr_dat) st_d.dat = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o = st_q.dir;
    assign dat_o = st_q.dat;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] dat_i,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] alt_en_i,
    input  logic [WIDTH-1:0] alt_val_i,
    output logic [WIDTH-1:0] oe_o,
    output logic [WIDTH-1:0] out_o,
    output logic [WIDTH-1:0] rb_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        assign oe_o[p]  = alt_en_i[p] | dir_i[p];
        assign out_o[p] = alt_en_i[p] ? alt_val_i[p] : dat_i[p];
        assign rb_o[p]  = dir_i[p] ? dat_i[p] : sync_i[p];
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned        ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]  DIR_OFS = 8'h8C,
    parameter logic [ADDR_W-1:0]  DAT_OFS = 8'h8E,
    parameter int unsigned        SYNC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    input  logic [PORT_W-1:0] alt_en,
    input  logic [PORT_W-1:0] alt_val
);
    logic              hit_dir;
    logic              hit_dat;
    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] dat_q;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] read_back;

    assign hit_dir = bus_sel && (bus_addr == DIR_OFS);
    assign hit_dat = bus_sel && (bus_addr == DAT_OFS);

    gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (pin_sync)
    );

    gpio_port_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_stby (hw_stby),
        .sw_stby (sw_stby),
        .wr_dir  (hit_dir && bus_wr),
        .wr_dat  (hit_dat && bus_wr),
        .wdata   (bus_wdata),
        .dir_o   (dir_q),
        .dat_o   (dat_q)
    );

    gpio_pin_drive #(.WIDTH(PORT_W)) u_drive (
        .dir_i     (dir_q),
        .dat_i     (dat_q),
        .sync_i    (pin_sync),
        .alt_en_i  (alt_en),
        .alt_val_i (alt_val),
        .oe_o      (pin_oe),
        .out_o     (pin_out),
        .rb_o      (read_back)
    );

    always_comb begin
        if (hit_dir)      bus_rdata = '1;
        else if (hit_dat) bus_rdata = read_back;
        else              bus_rdata = '0;
    end
endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int unsigned       WIDTH   = 8,
    parameter int unsigned       ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] DIR_OFS = 8'h8C,
    parameter logic [ADDR_W-1:0] DAT_OFS = 8'h8E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hw_stby,
    input logic              sw_stby,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  alt_en,
    input logic [WIDTH-1:0]  alt_val,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  dat_q
);
    logic unmapped;
    assign unmapped = (bus_addr != DIR_OFS) && (bus_addr != DAT_OFS);

    AST_DIR_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && bus_addr == DIR_OFS && !hw_stby && !sw_stby
        |=> dir_q == $past(bus_wdata)); // R1

    AST_DIR_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && bus_addr == DIR_OFS |-> bus_rdata == '1); // R2

    AST_HW_STBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_stby |=> dir_q == '0 && dat_q == '0); // R5

    AST_SW_STBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_stby && !hw_stby |=> $stable(dir_q) && $stable(dat_q)); // R6

    AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr && unmapped && !hw_stby |=> $stable(dir_q) && $stable(dat_q)); // R9

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && !bus_wr && unmapped |-> bus_rdata == '0); // R9

    always_comb begin
        if (rst_n) begin
            AST_ALT_OVERRIDE: assert ((pin_oe & alt_en) == alt_en &&
                                      (pin_out & alt_en) == (alt_val & alt_en)); // R10
        end
    end
endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .WIDTH   (gpio_port_pkg::PORT_W),
    .ADDR_W  (ADDR_W),
    .DIR_OFS (DIR_OFS),
    .DAT_OFS (DAT_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby   (hw_stby),
    .sw_stby   (sw_stby),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .alt_en    (alt_en),
    .alt_val   (alt_val),
    .dir_q     (dir_q),
    .dat_q     (dat_q)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int         kind;   // 0 = bus_rdata, 1 = pin_oe, 2 = pin_out
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_stby = 1'b0;
    logic       sw_stby = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe;
    logic [7:0] pin_out;
    logic [7:0] alt_en = '0;
    logic [7:0] alt_val = '0;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t sb_q[$];

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .alt_en(alt_en), .alt_val(alt_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = pin_oe;
                default: act = pin_out;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step();
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        step();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        step();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        it.kind = 0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic pin_chk(input logic [7:0] e_oe, input logic [7:0] e_out, input string tag);
        item_t it;
        step();
        bus_sel = 1'b0; bus_wr = 1'b0;
        it.kind = 1; it.exp = e_oe;  it.tag = tag; sb_q.push_back(it);
        it.kind = 2; it.exp = e_out; it.tag = tag; sb_q.push_back(it);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R4: reset state
        pin_chk(8'h00, 8'h00, "R4 reset pins");
        read_chk(8'h8E, 8'h00, "R4 reset data");
        // R2: direction reads as ones
        read_chk(8'h8C, 8'hFF, "R2 dir read at reset");

        // R1: low nibble outputs
        bus_write(8'h8E, 8'hA5);
        bus_write(8'h8C, 8'h0F);
        pin_chk(8'h0F, 8'hA5, "R1 dir write oe/out");
        read_chk(8'h8C, 8'hFF, "R2 dir read after write");

        // R7/R8: mixed read-back and two-stage synchronizer
        step(); bus_sel = 1'b0; pin_in = 8'h30;
        read_chk(8'h8E, 8'h05, "R8 not visible after first edge");
        read_chk(8'h8E, 8'h35, "R7 mixed readback after second edge");

        // R9: unmapped access
        bus_write(8'h8D, 8'hFF);
        bus_write(8'h8F, 8'hFF);
        pin_chk(8'h0F, 8'hA5, "R9 unmapped write ignored");
        read_chk(8'h8D, 8'h00, "R9 unmapped read 8D");
        read_chk(8'h8F, 8'h00, "R9 unmapped read 8F");

        // R3: data write leaves direction alone
        bus_write(8'h8E, 8'h3C);
        pin_chk(8'h0F, 8'h3C, "R3 data write keeps dir");

        // R6: software standby freezes registers
        step(); bus_sel = 1'b0; sw_stby = 1'b1;
        bus_write(8'h8C, 8'h00);
        bus_write(8'h8E, 8'h00);
        pin_chk(8'h0F, 8'h3C, "R6 sw standby holds");
        step(); sw_stby = 1'b0;
        pin_chk(8'h0F, 8'h3C, "R6 after sw standby exit");

        // R10: alternate function override
        step(); alt_en = 8'h84; alt_val = 8'h80;
        pin_chk(8'h8F, 8'hB8, "R10 alt override");
        step(); alt_en = 8'h00; alt_val = 8'h00;
        pin_chk(8'h0F, 8'h3C, "R10 alt released");

        // R5: hardware standby beats a same-cycle write
        step();
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h8C; bus_wdata = 8'hFF;
        hw_stby = 1'b1;
        step(); bus_sel = 1'b0; bus_wr = 1'b0; hw_stby = 1'b0;
        pin_chk(8'h00, 8'h00, "R5 hw standby clears");
        read_chk(8'h8E, 8'h30, "R5 data reads pins after clear");

        // R1: new direction after clear
        bus_write(8'h8C, 8'hF0);
        pin_chk(8'hF0, 8'h00, "R1 dir rewrite");
        idle();

        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule